// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block turns one 32-bit instruction word from a compact three-format load/store RISC subset into the control signals that a single-issue datapath needs. It splits the word into its register and immediate fields. It forms the 32-bit immediate with the extension that each instruction calls for. It then selects the ALU operation, the register write and its target, the memory strobes, the writeback source and the kind of control transfer.

The subset has twenty instructions. Opcode 0 is shared by eight register-format operations, which the low six bits tell apart. The other twelve have an opcode of their own. Any other encoding is reported as illegal, and an illegal word produces no side effect. The block is purely combinational and holds no state. The register file, ALU, memories and next-PC logic all sit outside it.

Top module: `risc_field_decoder`

## Requirements
- R1: `src_a_idx_o` equals bits [25:21] and `src_b_idx_o` equals bits [20:16] for every word. `dst_idx_o` is bits [15:11] when `dst_is_rd_o` is 1 and bits [20:16] when it is 0.
- R2: With opcode 0 (bits [31:26]), function code (bits [5:0]) 32, 34, 36, 37, 38, 39 and 42 selects ALU code 0 (add), 1 (sub), 2 (and), 3 (or), 4 (xor), 5 (nor) and 6 (set-less-than) respectively. Each of these writes the rd field (`dst_is_rd_o`=1), with writeback from the ALU (`wb_from_mem_o`=0).
- R3: Opcode 0 with function code 8 gives transfer class 5 (jump through register). It has no register write and no memory strobe.
- R4: Opcodes 8 and 10 sign-extend bits [15:0], select ALU code 0 and 6 respectively, and write the rt field.
- R5: Opcodes 12, 13 and 14 zero-extend bits [15:0], select ALU code 2, 3 and 4 respectively, and write the rt field.
- R6: Opcode 15 sets the immediate output to bits [15:0] followed by sixteen zeros. It selects ALU code 7 (pass the immediate) and writes the rt field.
- R7: Opcode 35 raises `mem_rd_o`, selects writeback from memory, writes rt, sign-extends the offset and uses ALU code 0. Opcode 43 raises `mem_wr_o`, sign-extends the offset, uses ALU code 0 and has no register write.
- R8: Opcodes 1, 4 and 5 give transfer classes 1, 2 and 3, with ALU codes 6, 1 and 1. Opcode 2 gives transfer class 4 with ALU code 0. All four sign-extend bits [15:0] and have no register write.
- R9: `reg_we_o` is 0 whenever `dst_idx_o` is 0, even for an instruction that writes.
- R10: Every other opcode, and opcode 0 with any other function code, raises `illegal_o`. It also forces `reg_we_o`, `mem_rd_o` and `mem_wr_o` to 0 and the transfer class to 0.
- R11: Any setting that R2 to R8 leave unspecified takes a default: ALU code 0, transfer class 0, writeback from the ALU, `dst_is_rd_o`=0, sign extension and both memory strobes 0. `illegal_o` is 0 for the twenty listed instructions, and the two memory strobes are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| src_a_idx_o | output | 5 | First source register index (rs) |
| src_b_idx_o | output | 5 | Second source register index (rt) |
| dst_idx_o | output | 5 | Selected write register index |
| dst_is_rd_o | output | 1 | 1: write target is rd, 0: rt |
| reg_we_o | output | 1 | Register write enable |
| imm_ext_o | output | 32 | Extended immediate |
| alu_op_o | output | 3 | ALU operation code |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| wb_from_mem_o | output | 1 | 1: writeback from memory, 0: from ALU |
| xfer_o | output | 3 | Control transfer class |
| illegal_o | output | 1 | Encoding outside the subset |

## Verification
The bound checker watches the invariants that must hold for every instruction word. An illegal word causes no write, strobe or transfer. No write goes to register 0. The two memory strobes never rise together. A store never writes a register. The logical immediates come out with a zero upper half, and the upper-immediate load comes out with a zero lower half. Only the bench's sweeps can show that each opcode and function code maps to the exact ALU code, transfer class and extension. They also show that every one of the 64 opcodes and 64 function codes outside the subset is refused, and that the register fields pass through unchanged under varied field patterns.

// File: rtl/risc_dec_pkg.sv
// Package: shared encodings for the instruction field decoder.
// Assumes a 6-bit opcode and function code in the fixed three-format layout.
package risc_dec_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    // Opcode values of the subset
    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OPC_BLTZ  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

    // Function codes under opcode 0
    localparam logic [FN_W-1:0] FN_JREG = 6'd8;
    localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FN_W-1:0] FN_AND  = 6'd36;
    localparam logic [FN_W-1:0] FN_OR   = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
    localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT  = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_NOR  = 3'd5,
        ALU_SLT  = 3'd6,
        ALU_PASS = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_BLTZ = 3'd1,
        XF_BEQ  = 3'd2,
        XF_BNE  = 3'd3,
        XF_JUMP = 3'd4,
        XF_JREG = 3'd5
    } xfer_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef struct packed {
        logic      legal;
        logic      writes;
        logic      dst_is_rd;
        logic      mem_rd;
        logic      mem_wr;
        logic      wb_mem;
        alu_op_e   alu;
        xfer_e     xfer;
        ext_mode_e ext;
    } ctrl_t;

endpackage

// File: rtl/risc_dec_fields.sv
// Module: splits an instruction word into opcode, register and immediate fields.
// Assumes the fixed layout: opcode on top, then rs, rt, rd, and the immediate in the low bits.
module risc_dec_fields #(
    parameter int INSTR_W = 32,
    parameter int IDX_W   = 5,
    parameter int IMM_W   = 16
) (
    input  logic [INSTR_W-1:0]              instr,
    output logic [risc_dec_pkg::OPC_W-1:0]  opc,
    output logic [risc_dec_pkg::FN_W-1:0]   fn,
    output logic [IDX_W-1:0]                rs,
    output logic [IDX_W-1:0]                rt,
    output logic [IDX_W-1:0]                rd,
    output logic [IMM_W-1:0]                imm
);
    localparam int OPC_LSB = INSTR_W - risc_dec_pkg::OPC_W;
    localparam int RS_LSB  = OPC_LSB - IDX_W;
    localparam int RT_LSB  = RS_LSB - IDX_W;
    localparam int RD_LSB  = RT_LSB - IDX_W;

    // Slice each field out of the word
    always_comb begin
        opc = instr[INSTR_W-1:OPC_LSB];
        rs  = instr[OPC_LSB-1:RS_LSB];
        rt  = instr[RS_LSB-1:RT_LSB];
        rd  = instr[RT_LSB-1:RD_LSB];
        fn  = instr[risc_dec_pkg::FN_W-1:0];
        imm = instr[IMM_W-1:0];
    end
endmodule

// File: rtl/risc_dec_ctrl.sv
// Module: maps opcode and function code to a control bundle.
// Assumes nothing beyond the two codes; unknown codes leave legal low and every effect off.
module risc_dec_ctrl
    import risc_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [FN_W-1:0]  fn,
    output ctrl_t            ctrl
);
    // Register-format arm: decode the function code
    function automatic ctrl_t rtype(input logic [FN_W-1:0] f);
        ctrl_t c;
        c = '{legal: 1'b1, writes: 1'b1, dst_is_rd: 1'b1, mem_rd: 1'b0, mem_wr: 1'b0,
              wb_mem: 1'b0, alu: ALU_ADD, xfer: XF_NONE, ext: EXT_SIGN};
        case (f)
            FN_ADD:  c.alu = ALU_ADD;
            FN_SUB:  c.alu = ALU_SUB;
            FN_AND:  c.alu = ALU_AND;
            FN_OR:   c.alu = ALU_OR;
            FN_XOR:  c.alu = ALU_XOR;
            FN_NOR:  c.alu = ALU_NOR;
            FN_SLT:  c.alu = ALU_SLT;
            FN_JREG: begin
                c.writes    = 1'b0;
                c.dst_is_rd = 1'b0;
                c.xfer      = XF_JREG;
            end
            default: begin
                c.legal     = 1'b0;
                c.writes    = 1'b0;
                c.dst_is_rd = 1'b0;
            end
        endcase
        return c;
    endfunction

    // Main decode on the opcode
    always_comb begin
        ctrl = '{legal: 1'b0, writes: 1'b0, dst_is_rd: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                 wb_mem: 1'b0, alu: ALU_ADD, xfer: XF_NONE, ext: EXT_SIGN};
        case (opc)
            OPC_RTYPE: ctrl = rtype(fn);
            OPC_BLTZ:  begin ctrl.legal = 1'b1; ctrl.alu = ALU_SLT; ctrl.xfer = XF_BLTZ; end
            OPC_BEQ:   begin ctrl.legal = 1'b1; ctrl.alu = ALU_SUB; ctrl.xfer = XF_BEQ;  end
            OPC_BNE:   begin ctrl.legal = 1'b1; ctrl.alu = ALU_SUB; ctrl.xfer = XF_BNE;  end
            OPC_JMP:   begin ctrl.legal = 1'b1; ctrl.xfer = XF_JUMP; end
            OPC_ADDI:  begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_ADD; end
            OPC_SLTI:  begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_SLT; end
            OPC_ANDI:  begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_AND; ctrl.ext = EXT_ZERO; end
            OPC_ORI:   begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_OR;  ctrl.ext = EXT_ZERO; end
            OPC_XORI:  begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_XOR; ctrl.ext = EXT_ZERO; end
            OPC_LUI:   begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.alu = ALU_PASS; ctrl.ext = EXT_UPPER; end
            OPC_LOAD:  begin ctrl.legal = 1'b1; ctrl.writes = 1'b1; ctrl.mem_rd = 1'b1; ctrl.wb_mem = 1'b1; end
            OPC_STORE: begin ctrl.legal = 1'b1; ctrl.mem_wr = 1'b1; end
            default:   ctrl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/risc_dec_immext.sv
// Module: widens the immediate field by sign, zero or upper-half placement.
// Assumes XLEN is at least IMM_W; when equal, the field passes unchanged.
module risc_dec_immext
    import risc_dec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    input  ext_mode_e        mode,
    output logic [XLEN-1:0]  ext
);
    localparam int PAD_W = XLEN - IMM_W;

    generate
        if (PAD_W > 0) begin : g_widen
            // Pick the extension for the current instruction
            always_comb begin
                case (mode)
                    EXT_ZERO:  ext = {{PAD_W{1'b0}}, imm};
                    EXT_UPPER: ext = {imm, {PAD_W{1'b0}}};
                    default:   ext = {{PAD_W{imm[IMM_W-1]}}, imm};
                endcase
            end
        end else begin : g_same
            logic unused_mode;
            // Field already fills the word
            always_comb begin
                ext         = imm;
                unused_mode = ^mode;
            end
        end
    endgenerate
endmodule

// File: rtl/risc_field_decoder.sv
// Module: top of the instruction field decoder; purely combinational.
// Assumes the three-format 32-bit encoding; register index 0 is hard-wired zero.
module risc_field_decoder
    import risc_dec_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  instr_i,
    output logic [IDX_W-1:0] src_a_idx_o,
    output logic [IDX_W-1:0] src_b_idx_o,
    output logic [IDX_W-1:0] dst_idx_o,
    output logic             dst_is_rd_o,
    output logic             reg_we_o,
    output logic [XLEN-1:0]  imm_ext_o,
    output logic [2:0]       alu_op_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             wb_from_mem_o,
    output logic [2:0]       xfer_o,
    output logic             illegal_o
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    logic [IDX_W-1:0] rs, rt, rd;
    logic [IMM_W-1:0] imm;
    ctrl_t            ctrl;

    risc_dec_fields #(.INSTR_W(XLEN), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_fields (
        .instr (instr_i), .opc(opc), .fn(fn), .rs(rs), .rt(rt), .rd(rd), .imm(imm)
    );

    risc_dec_ctrl u_ctrl (.opc(opc), .fn(fn), .ctrl(ctrl));

    risc_dec_immext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
        .imm(imm), .mode(ctrl.ext), .ext(imm_ext_o)
    );

    // Drive the outputs, suppressing writes to index 0 and any effect of an illegal word
    always_comb begin
        src_a_idx_o   = rs;
        src_b_idx_o   = rt;
        dst_is_rd_o   = ctrl.dst_is_rd;
        dst_idx_o     = ctrl.dst_is_rd ? rd : rt;
        reg_we_o      = ctrl.legal & ctrl.writes & (dst_idx_o != '0);
        mem_rd_o      = ctrl.legal & ctrl.mem_rd;
        mem_wr_o      = ctrl.legal & ctrl.mem_wr;
        wb_from_mem_o = ctrl.wb_mem;
        alu_op_o      = ctrl.alu;
        xfer_o        = ctrl.legal ? ctrl.xfer : XF_NONE;
        illegal_o     = ~ctrl.legal;
    end
endmodule

// File: rtl/risc_field_decoder_chk.sv
// Module: invariant checker for the field decoder, attached by bind.
// Assumes the top's default widths; checks settle-time values of the outputs.
module risc_field_decoder_chk (
    input logic [31:0] instr_i,
    input logic [4:0]  dst_idx_o,
    input logic        reg_we_o,
    input logic [31:0] imm_ext_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [2:0]  xfer_o,
    input logic        illegal_o
);
    // Check the decoder invariants whenever the word or outputs move
    always_comb begin
        if (illegal_o)
            assert_illegal_quiet_R10: assert (!reg_we_o && !mem_rd_o && !mem_wr_o && xfer_o == 3'd0);
        if (reg_we_o)
            assert_no_zero_write_R9: assert (dst_idx_o != 5'd0);
        assert_mem_exclusive_R11: assert (!(mem_rd_o && mem_wr_o));
        if (mem_wr_o)
            assert_store_nowrite_R7: assert (!reg_we_o && !illegal_o);
        if (instr_i[31:26] == 6'd15)
            assert_upper_place_R6: assert (imm_ext_o == {instr_i[15:0], 16'h0000});
        if (instr_i[31:26] >= 6'd12 && instr_i[31:26] <= 6'd14)
            assert_zero_ext_R5: assert (imm_ext_o[31:16] == 16'h0000);
    end
endmodule

bind risc_field_decoder risc_field_decoder_chk u_chk (
    .instr_i  (instr_i),
    .dst_idx_o(dst_idx_o),
    .reg_we_o (reg_we_o),
    .imm_ext_o(imm_ext_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o),
    .xfer_o   (xfer_o),
    .illegal_o(illegal_o)
);

// File: tb/risc_field_decoder_tb.sv
// Bench: sweeps every opcode and every register-format function code under several field patterns.
module risc_field_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr;
    logic [4:0]  src_a, src_b, dst;
    logic        dst_rd, we, mrd, mwr, wbm, ill;
    logic [31:0] immx;
    logic [2:0]  aop, xf;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    risc_field_decoder u_dut (
        .instr_i(instr), .src_a_idx_o(src_a), .src_b_idx_o(src_b), .dst_idx_o(dst),
        .dst_is_rd_o(dst_rd), .reg_we_o(we), .imm_ext_o(immx), .alu_op_o(aop),
        .mem_rd_o(mrd), .mem_wr_o(mwr), .wb_from_mem_o(wbm), .xfer_o(xf), .illegal_o(ill)
    );

    // Expected bundle: {ill, we, dst_rd, dst, mrd, mwr, wbm, aop, xf, immx}
    function automatic logic [48:0] model(input logic [31:0] w);
        int op, fn, alu, xc, ext; bit ok, wr, rdsel, lr, sw, wm;
        logic [31:0] im; logic [4:0] d;
        op = int'(w[31:26]); fn = int'(w[5:0]);
        ok = 1; wr = 0; rdsel = 0; lr = 0; sw = 0; wm = 0; alu = 0; xc = 0; ext = 0;
        if (op == 0) begin
            if (fn == 32) begin wr = 1; rdsel = 1; alu = 0; end
            else if (fn == 34) begin wr = 1; rdsel = 1; alu = 1; end
            else if (fn >= 36 && fn <= 39) begin wr = 1; rdsel = 1; alu = fn - 34; end
            else if (fn == 42) begin wr = 1; rdsel = 1; alu = 6; end
            else if (fn == 8) xc = 5;
            else ok = 0;
        end
        else if (op == 1) begin alu = 6; xc = 1; end
        else if (op == 4 || op == 5) begin alu = 1; xc = op - 2; end
        else if (op == 2) xc = 4;
        else if (op == 8) wr = 1;
        else if (op == 10) begin wr = 1; alu = 6; end
        else if (op >= 12 && op <= 14) begin wr = 1; alu = op - 10; ext = 1; end
        else if (op == 15) begin wr = 1; alu = 7; ext = 2; end
        else if (op == 35) begin wr = 1; lr = 1; wm = 1; end
        else if (op == 43) sw = 1;
        else ok = 0;
        if (!ok) begin wr = 0; rdsel = 0; alu = 0; xc = 0; end
        if (ext == 1) im = {16'h0, w[15:0]};
        else if (ext == 2) im = {w[15:0], 16'h0};
        else im = {{16{w[15]}}, w[15:0]};
        d = rdsel ? w[15:11] : w[20:16];
        if (d == 5'd0) wr = 0;
        return {!ok, wr, rdsel, d, lr, sw, wm, alu[2:0], xc[2:0], im};
    endfunction

    function automatic string tag_of(input logic [31:0] w);
        int op; op = int'(w[31:26]);
        if (op == 0 && w[5:0] == 6'd8) return "R3";
        if (op == 0) return (w[5:0] >= 6'd32 && w[5:0] <= 6'd42) ? "R2/R10" : "R10";
        if (op == 8 || op == 10) return "R4";
        if (op >= 12 && op <= 14) return "R5";
        if (op == 15) return "R6";
        if (op == 35 || op == 43) return "R7";
        if (op == 1 || op == 2 || op == 4 || op == 5) return "R8";
        return "R10";
    endfunction

    task automatic apply(input logic [31:0] w);
        logic [48:0] exp_v, act;
        @(negedge clk);
        instr = w;
        #1;
        exp_v = model(w);
        act   = {ill, we, dst_rd, dst, mrd, mwr, wbm, aop, xf, immx};
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s/R11 instr=%h actual=%h expected=%h", tag_of(w), w, act, exp_v);
        end
        n_chk++;
        if (src_a !== w[25:21] || src_b !== w[20:16]) begin // R1
            n_fail++;
            $display("FAIL R1 instr=%h actual=%h_%h expected=%h_%h", w, src_a, src_b, w[25:21], w[20:16]);
        end
        if (exp_v[47] == 1'b0 && exp_v[45:41] == 5'd0 && exp_v[48] == 1'b0) begin
            n_chk++;
            if (we !== 1'b0) begin // R9
                n_fail++;
                $display("FAIL R9 instr=%h actual=%b expected=0", w, we);
            end
        end
    endtask

    // Field patterns laid over each opcode: rs, rt, rd, shamt and low bits
    function automatic logic [25:0] pat(input int k);
        case (k)
            0: return 26'h0000000;
            1: return 26'h3FFFFFF;
            2: return 26'h12A_8F35;
            3: return 26'h1E0_07C1;
            4: return 26'h000_8000;
            default: return 26'h015_7FFF;
        endcase
    endfunction

    initial begin
        instr = 32'h0;
        repeat (3) @(posedge clk);
        #2;
        n_chk++; // reset state: all-zero word is outside the subset (R10)
        if (ill !== 1'b1 || we !== 1'b0 || mrd !== 1'b0 || mwr !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset word actual=%b%b%b%b expected=1000", ill, we, mrd, mwr);
        end
        rst_n = 1'b1;
        for (int op = 0; op < 64; op++)
            for (int k = 0; k < 6; k++)
                apply({op[5:0], pat(k)});
        for (int fn = 0; fn < 64; fn++)
            for (int k = 0; k < 6; k++)
                apply({6'd0, pat(k)[25:6], fn[5:0]});
        // rd and rt both zero with writing forms: R9
        apply(32'h0000_0020);
        apply(32'h2000_1234);
        apply(32'h8C20_0004);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule